// File: doc/BRIEF.md
# Byte-Configured GPIO Bank with Pad Function Select

This block drives a row of I/O pads and takes its settings from a Wishbone slave port. Each pin has one configuration byte. A bus word holds as many of these bytes as it has byte lanes, so one 64-bit word covers eight pins. A single byte write fully sets one pin: its function select, its pulls, its direction enables and its output level. Software therefore never has to read the register before changing it. This still holds when an upstream narrow adapter breaks a wide write into separate byte writes.

A 3-bit function field in each byte decides what drives the pad. Function 0 is plain register-driven GPIO. Functions 1 to `NALT` route the pad's output, output enable and input enable to an alternate-peripheral port of that pin. The pull controls always stay with the register. The pad input level is sent to every peripheral port of its pin and also appears in the register read-back. Unused function codes leave the pad tri-stated with its input disabled.

Top module: `gpio_bytemux`

## Requirements
- R1: Pin number = word address × bytes-per-word + byte lane. In a pin's byte, bits 7:5 are the function select, bit 4 is the data bit, bit 3 is pull-down, bit 2 is pull-up, bit 1 is input enable and bit 0 is output enable.
- R2: A write with `wb_sel[k]` set replaces pin k's whole byte in that one access. Bytes whose lane select is clear keep their value. Writing the bytes one lane at a time gives the same end state as one full-word write.
- R3: A read returns every stored byte of the addressed word, with bit 4 replaced by that pin's current `pad_i`.
- R4: With function 0, `pad_o`, `pad_oe` and `pad_ie` equal byte bits 4, 0 and 1.
- R5: With function b (1..NALT), `pad_o`, `pad_oe` and `pad_ie` equal `alt_o`, `alt_oe` and `alt_ie` at index pin×NALT + (b−1). Byte bits 4, 1 and 0 have no effect.
- R6: `pad_pu` equals bit 2 and `pad_pd` equals bit 3 AND NOT bit 2, whatever the function. Pull-up wins when both bits are set.
- R7: A function code above NALT drives `pad_o`, `pad_oe` and `pad_ie` to 0.
- R8: `alt_i` at index pin×NALT + (b−1) equals `pad_i` of that pin for every b.
- R9: `wb_ack` pulses for one cycle, in the cycle after `wb_cyc` and `wb_stb` are sampled high. Read data is valid while `wb_ack` is high.
- R10: Reset clears every byte, so all pads come up with no drive, no input enable and no pulls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | AW | Word address |
| wb_sel | input | NB | Byte-lane selects |
| wb_dat_w | input | BUS_W | Write data |
| wb_dat_r | output | BUS_W | Read data |
| wb_ack | output | 1 | Acknowledge |
| pad_i | input | NPIN | Pad input levels |
| pad_o | output | NPIN | Pad output levels |
| pad_oe | output | NPIN | Pad output enables |
| pad_ie | output | NPIN | Pad input enables |
| pad_pu | output | NPIN | Pull-up enables |
| pad_pd | output | NPIN | Pull-down enables |
| alt_o | input | NPIN×NALT | Peripheral output per pin and function |
| alt_oe | input | NPIN×NALT | Peripheral output enable per pin and function |
| alt_ie | input | NPIN×NALT | Peripheral input enable per pin and function |
| alt_i | output | NPIN×NALT | Pad input copied to each peripheral |

## Verification
A corrupted configuration byte becomes visible at the pads at the next check. The pad signals are combinational from the stored byte, so a wrong function select, pull or enable appears in the cycle after the write that caused it. Lane-select or address-decode faults change a neighbouring pin's byte. That change shows up on that pin's pads and in the read-back of its word, which is compared one cycle after the read request. Routing mistakes on the peripheral side show up as a pad following the wrong `alt_*` index. The stimulus gives every function slot a distinct pattern so that such a mix-up is detected.

// File: rtl/gpio_bytemux.sv
module gpio_bytemux #(
  parameter int BUS_W  = 64,
  parameter int NWORDS = 2,
  parameter int NALT   = 3,
  localparam int NB    = BUS_W / 8,
  localparam int NPIN  = NWORDS * NB,
  localparam int AW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wb_cyc,
  input  logic                 wb_stb,
  input  logic                 wb_we,
  input  logic [AW-1:0]        wb_adr,
  input  logic [NB-1:0]        wb_sel,
  input  logic [BUS_W-1:0]     wb_dat_w,
  output logic [BUS_W-1:0]     wb_dat_r,
  output logic                 wb_ack,
  input  logic [NPIN-1:0]      pad_i,
  output logic [NPIN-1:0]      pad_o,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_ie,
  output logic [NPIN-1:0]      pad_pu,
  output logic [NPIN-1:0]      pad_pd,
  input  logic [NPIN*NALT-1:0] alt_o,
  input  logic [NPIN*NALT-1:0] alt_oe,
  input  logic [NPIN*NALT-1:0] alt_ie,
  output logic [NPIN*NALT-1:0] alt_i
);

  logic [7:0]      cfg [NPIN];
  logic            req;
  logic [NPIN-1:0] wr_hit;
  logic [BUS_W-1:0] rd_word;

  assign req = wb_cyc & wb_stb & ~wb_ack;

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NWORDS; w++)
      if (wb_adr == AW'(w))
        for (int k = 0; k < NB; k++)
          rd_word[8*k +: 8] = {cfg[w*NB+k][7:5], pad_i[w*NB+k], cfg[w*NB+k][3:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack   <= 1'b0;
      wb_dat_r <= '0;
      for (int p = 0; p < NPIN; p++) cfg[p] <= 8'h00;
    end else begin
      wb_ack <= req;
      if (req && !wb_we) wb_dat_r <= rd_word;
      for (int p = 0; p < NPIN; p++)
        if (wr_hit[p]) cfg[p] <= wb_dat_w[8*(p%NB) +: 8];
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [2:0] fsel;
    assign fsel      = cfg[p][7:5];
    assign wr_hit[p] = req & wb_we & (wb_adr == AW'(p / NB)) & wb_sel[p % NB];
    assign pad_pu[p] = cfg[p][2];
    assign pad_pd[p] = cfg[p][3] & ~cfg[p][2];
    assign alt_i[p*NALT +: NALT] = {NALT{pad_i[p]}};

    always_comb begin
      pad_o[p]  = 1'b0;
      pad_oe[p] = 1'b0;
      pad_ie[p] = 1'b0;
      if (fsel == 3'd0) begin
        pad_o[p]  = cfg[p][4];
        pad_oe[p] = cfg[p][0];
        pad_ie[p] = cfg[p][1];
      end else begin
        for (int a = 1; a <= NALT; a++)
          if (fsel == 3'(a)) begin
            pad_o[p]  = alt_o[p*NALT + a - 1];
            pad_oe[p] = alt_oe[p*NALT + a - 1];
            pad_ie[p] = alt_ie[p*NALT + a - 1];
          end
      end
    end

    // R6
    pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(pad_pu[p] && pad_pd[p]));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_hit[p] |=> $stable(cfg[p]));
  end

  // R9
  ack_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(wb_cyc && wb_stb));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

endmodule

// File: tb/gpio_bytemux_tb_top.sv
module gpio_bytemux_tb_top;
  localparam int BUS_W = 64, NWORDS = 2, NALT = 3;
  localparam int NB = BUS_W / 8, NPIN = NWORDS * NB, AW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [AW-1:0] wb_adr = '0;
  logic [NB-1:0] wb_sel = '0;
  logic [BUS_W-1:0] wb_dat_w = '0, wb_dat_r;
  logic wb_ack;
  logic [NPIN-1:0] pad_i = '0, pad_o, pad_oe, pad_ie, pad_pu, pad_pd;
  logic [NPIN*NALT-1:0] alt_o = '0, alt_oe = '0, alt_ie = '0, alt_i;

  int checks = 0, errors = 0;
  logic [7:0] model [NPIN];
  logic [BUS_W-1:0] expq [$];

  always #10 clk = ~clk;

  gpio_bytemux #(.BUS_W(BUS_W), .NWORDS(NWORDS), .NALT(NALT)) dut_i (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .pad_ie(pad_ie), .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_o(alt_o),
    .alt_oe(alt_oe), .alt_ie(alt_ie), .alt_i(alt_i));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] exp_word(input int w);
    logic [BUS_W-1:0] r = '0;
    for (int k = 0; k < NB; k++)
      r[8*k +: 8] = {model[w*NB+k][7:5], pad_i[w*NB+k], model[w*NB+k][3:0]};
    return r;
  endfunction

  // monitor: pops expected read words when ack appears on a read
  always @(posedge clk) begin
    #2;
    if (wb_ack && !wb_we) begin
      if (expq.size() == 0) check("R9 unexpected read ack", 64'd1, 64'd0);
      else check("R3 R1 read word", wb_dat_r, expq.pop_front());
    end
  end

  task automatic bus(input logic we, input int adr, input logic [NB-1:0] sel,
                     input logic [BUS_W-1:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = AW'(adr); wb_sel = sel; wb_dat_w = d;
    if (!we) expq.push_back(exp_word(adr));
    else for (int k = 0; k < NB; k++) if (sel[k]) model[adr*NB+k] = d[8*k +: 8];
    @(negedge clk);
    check("R9 ack one cycle after request", 64'(wb_ack), 64'd1);
    wb_cyc = 0; wb_stb = 0;
    @(negedge clk);
    check("R9 ack single pulse", 64'(wb_ack), 64'd0);
  endtask

  task automatic check_pads();
    for (int p = 0; p < NPIN; p++) begin
      logic [7:0] m = model[p];
      logic [2:0] e;
      string tag;
      if (m[7:5] == 0) begin e = {m[4], m[0], m[1]}; tag = "R4 function 0"; end
      else if (m[7:5] <= NALT) begin
        e = {alt_o[p*NALT+m[7:5]-1], alt_oe[p*NALT+m[7:5]-1], alt_ie[p*NALT+m[7:5]-1]};
        tag = "R5 alternate function";
      end else begin e = 3'b000; tag = "R7 reserved function"; end
      check(tag, 64'({pad_o[p], pad_oe[p], pad_ie[p]}), 64'(e));
      check("R6 pulls", 64'({pad_pu[p], pad_pd[p]}), 64'({m[2], m[3] & ~m[2]}));
      check("R8 alt input copy", 64'(alt_i[p*NALT +: NALT]), 64'({NALT{pad_i[p]}}));
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPIN; p++) model[p] = 8'h00;
    pad_i = 16'hA5C3;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state at pads and read-back
    check("R10 reset pads", 64'({pad_oe, pad_ie, pad_pu, pad_pd}), 64'd0);
    check_pads();
    bus(0, 0, '1, '0);
    bus(0, 1, '1, '0);

    alt_o = 48'h5A5_F0F_3C3_C3C; alt_oe = 48'hF0F_0F0_AAA_555; alt_ie = 48'h333_CCC_969_696;
    // R1 R2 R4 R5 R6 R7: every function kind on word 0
    bus(1, 0, '1, 64'hE7_6C_5B_83_3D_13_02_11);
    check_pads();
    bus(0, 0, '1, '0);

    // R2 lane selects: only lanes 0 and 2 of word 1
    bus(1, 1, 8'b0000_0101, 64'hFF_FF_FF_FF_FF_31_FF_4E);
    check_pads();
    bus(0, 1, '1, '0);
    check("R2 unselected lane stays", 64'(pad_pu[9]), 64'd0);

    // R3 read-back follows pad input
    pad_i = 16'h3C96;
    @(negedge clk);
    check_pads();
    bus(0, 0, '1, '0);
    bus(0, 1, '1, '0);

    // R5 peripheral pattern change; register bits ignored
    alt_o = ~alt_o; alt_oe = {alt_oe[23:0], alt_oe[47:24]}; alt_ie = ~alt_ie;
    @(negedge clk);
    check_pads();

    // R2 byte-by-byte writes equal a full-word write
    for (int k = 0; k < NB; k++)
      bus(1, 1, NB'(1) << k, 64'h1D_7F_2B_A3_4C_9E_06_55 & (64'hFF << (8*k)));
    check_pads();
    bus(0, 1, '1, '0);
    for (int k = 0; k < NB; k++)
      bus(1, 0, NB'(1) << k, {8{8'h10 | 8'(k)}});
    check_pads();
    bus(0, 0, '1, '0);

    // R10 reset again clears everything
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    for (int p = 0; p < NPIN; p++) model[p] = 8'h00;
    @(negedge clk);
    check("R10 pads after second reset", 64'({pad_oe, pad_ie, pad_pu, pad_pd, pad_o}), 64'd0);

    repeat (3) @(negedge clk);
    check("R3 all reads answered", 64'(expq.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule